// File: doc/BRIEF.md
# SDRAM Write Burst Capture

This block is the device-side write path of a synchronous DRAM model. It decodes the command lines on every rising clock edge and turns each WRITE command into a run of stores into a small storage array that is split into banks. The bank and starting column come with the command. The first data word is taken on that same edge. Each later word goes to the next column of the burst, one per clock, until the burst completes or another command cuts it short.

Fixed bursts of 1, 2, 4 or 8 words stay inside their aligned column block. A full-page burst runs until it is stopped and wraps from the top column back to zero. READ, BURST TERMINATE, a PRECHARGE that covers the bursting bank, or a new WRITE each end a running burst, and each has its own rule for the data on its edge. A per-bank open flag is set by ACTIVE and cleared by PRECHARGE. A burst that requested auto precharge also clears that flag when it completes on its own. A probe port reads the array so the stored contents can be observed.

Top module: `sdram_wr_capture`

## Requirements
- R1: The command is decoded from {cs_n, ras_n, cas_n, we_n}. WRITE is 0100, READ 0101, ACTIVE 0011, PRECHARGE 0010 and BURST TERMINATE 0110, and any code with cs_n high does nothing. A WRITE stores din at bank ba and column addr[7:0] on its own edge.
- R2: A fixed burst stores one word per following edge. blen_sel 0, 1, 2 and 3 give lengths 1, 2, 4 and 8. The column increments inside its aligned block, so with length 4 a start of 5 writes columns 5, 6, 7 and 4.
- R3: Once a fixed burst has stored its last slot, burst_on is low on the next cycle and later data writes nothing.
- R4: Any blen_sel of 4 or more selects a full-page burst. It keeps storing one word per edge and wraps from column 255 to column 0.
- R5: A WRITE that arrives during a burst ends the old burst, and the data on its edge goes to the new burst's start column.
- R6: A READ during a burst ends it, and the data on the READ edge is not stored.
- R7: A BURST TERMINATE during a burst ends it, and the data on its edge is not stored. The last stored word is the one from the edge before.
- R8: A slot whose dqm is high stores nothing but still advances the column and uses up one slot of the burst.
- R9: ACTIVE sets bank_open[ba]. A WRITE with addr[10] high clears bank_open of its bank on the edge of its last slot, but only when the burst completes without truncation.
- R10: PRECHARGE clears bank_open[ba], or every bank when addr[10] is high. It ends a running burst only when it covers the burst's bank, and then the data on its edge is not stored. A PRECHARGE to another bank lets the burst carry on storing.
- R11: pre_err is high for one cycle after a PRECHARGE that ended a burst, if dqm was low on that PRECHARGE edge or on the edge before it.
- R12: After reset, burst_on is low, bank_open is all zero, pre_err is low and every array cell reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| ba | input | 2 | Bank address |
| addr | input | 11 | Address; [7:0] column, [10] auto precharge / all banks |
| din | input | 8 | Write data |
| dqm | input | 1 | Data mask, high drops the word |
| blen_sel | input | 3 | Burst length select |
| peek_bank | input | 2 | Probe bank |
| peek_col | input | 8 | Probe column |
| peek_data | output | 8 | Array contents at the probe address |
| burst_on | output | 1 | A burst will take a data slot on the next edge |
| bank_open | output | 4 | Per-bank open flag |
| pre_err | output | 1 | Mask rule broken on a truncating PRECHARGE |

## Verification
A wrong slot count or a wrong column step does not show up at once. It appears as burst_on staying high or dropping one cycle off, and as a store to the wrong cell, which the probe exposes on the cycle after that edge. A wrong truncation rule shows the same way: one word too many or too few at the cell the reference model expects. A mistake in the auto-precharge or mask bookkeeping appears in bank_open or pre_err on the cycle after the edge that caused it. The bench compares these outputs every cycle and also probes the last addressed cell every cycle, then sweeps the whole array at the end.

// File: rtl/sdram_wc_pkg.sv
package sdram_wc_pkg;
  localparam int COL_W = 8;
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    C_NONE, C_ACT, C_RD, C_WR, C_BST, C_PRE
  } cmd_e;

  // burst length from select code; codes above 3 mean full page
  function automatic logic [LEN_W-1:0] len_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return LEN_W'(1);
      3'd1:    return LEN_W'(2);
      3'd2:    return LEN_W'(4);
      3'd3:    return LEN_W'(8);
      default: return LEN_W'(0);
    endcase
  endfunction

  function automatic logic is_full(input logic [2:0] sel);
    return sel > 3'd3;
  endfunction

  // next column, wrapping inside the aligned block (whole page when full)
  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [LEN_W-1:0] len,
                                                input logic full);
    logic [COL_W-1:0] m;
    m = full ? {COL_W{1'b1}} : COL_W'(len - LEN_W'(1));
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction
endpackage

// File: rtl/wc_cmd_decode.sv
module wc_cmd_decode
  import sdram_wc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wc_burst.sv
module wc_burst
  import sdram_wc_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic [COL_W-1:0] col,
  input  logic             a10,
  input  logic             dqm,
  input  logic [2:0]       blen_sel,
  output logic             busy,
  output logic             wr_fire,
  output logic [BA_W-1:0]  wr_bank,
  output logic [COL_W-1:0] wr_col,
  output logic             ap_close,
  output logic             trunc_pre,
  output logic             pre_err
);
  logic [BA_W-1:0]  cur_bank;
  logic [COL_W-1:0] cur_col;
  logic [LEN_W-1:0] cur_len, left;
  logic             cur_full, cur_ap, dqm_q;

  logic             start, hits_pre, stop, slot, last, slot_full;
  logic [LEN_W-1:0] slot_len, new_len;

  assign new_len   = len_of(blen_sel);
  assign start     = (cmd == C_WR);
  assign hits_pre  = (cmd == C_PRE) && (a10 || bank == cur_bank);
  assign stop      = busy && !start &&
                     ((cmd == C_RD) || (cmd == C_BST) || hits_pre);
  assign slot      = start || (busy && !stop);
  assign wr_bank   = start ? bank : cur_bank;
  assign wr_col    = start ? col : cur_col;
  assign wr_fire   = slot && !dqm;
  assign slot_len  = start ? new_len : cur_len;
  assign slot_full = start ? is_full(blen_sel) : cur_full;
  assign last      = !slot_full && (start ? (new_len == LEN_W'(1)) : (left == LEN_W'(1)));
  assign ap_close  = slot && last && (start ? a10 : cur_ap);
  assign trunc_pre = stop && (cmd == C_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_bank <= '0;
      cur_col  <= '0;
      cur_len  <= '0;
      left     <= '0;
      cur_full <= 1'b0;
      cur_ap   <= 1'b0;
      dqm_q    <= 1'b1;
      pre_err  <= 1'b0;
    end else begin
      dqm_q   <= dqm;
      pre_err <= trunc_pre && (!dqm || !dqm_q);
      if (start) begin
        busy     <= !last;
        cur_bank <= bank;
        cur_col  <= step_col(col, slot_len, slot_full);
        cur_len  <= new_len;
        left     <= new_len - LEN_W'(1);
        cur_full <= slot_full;
        cur_ap   <= a10;
      end else if (stop) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        cur_col <= step_col(cur_col, slot_len, slot_full);
        left    <= left - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/wc_store.sv
module wc_store #(
  parameter int NB    = 4,
  parameter int COLS  = 256,
  parameter int DW    = 8,
  localparam int BA_W = $clog2(NB),
  localparam int CW   = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [BA_W-1:0] wbank,
  input  logic [CW-1:0]   wcol,
  input  logic [DW-1:0]   wdata,
  input  logic [BA_W-1:0] rbank,
  input  logic [CW-1:0]   rcol,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] cells [NB*COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB*COLS; i++) cells[i] <= '0;
    end else if (we) begin
      cells[{wbank, wcol}] <= wdata;
    end
  end

  assign rdata = cells[{rbank, rcol}];
endmodule

// File: rtl/sdram_wr_capture.sv
module sdram_wr_capture
  import sdram_wc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DW     = 8,
  parameter int AW     = 11,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             dqm,
  input  logic [2:0]       blen_sel,
  input  logic [BA_W-1:0]  peek_bank,
  input  logic [COL_W-1:0] peek_col,
  output logic [DW-1:0]    peek_data,
  output logic             burst_on,
  output logic [NB-1:0]    bank_open,
  output logic             pre_err
);
  cmd_e             cmd;
  logic             wr_fire, ap_close, trunc_pre;
  logic [BA_W-1:0]  wr_bank;
  logic [COL_W-1:0] wr_col;

  wc_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  wc_burst #(.BA_W(BA_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(ba), .col(addr[COL_W-1:0]),
    .a10(addr[AP_BIT]), .dqm(dqm), .blen_sel(blen_sel), .busy(burst_on),
    .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_col(wr_col),
    .ap_close(ap_close), .trunc_pre(trunc_pre), .pre_err(pre_err)
  );

  wc_store #(.NB(NB), .COLS(1 << COL_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .wbank(wr_bank), .wcol(wr_col),
    .wdata(din), .rbank(peek_bank), .rcol(peek_col), .rdata(peek_data)
  );

  // open flags: auto precharge close, then PRECHARGE, then ACTIVE wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_open <= '0;
    end else begin
      logic [NB-1:0] nxt;
      nxt = bank_open;
      if (ap_close) nxt[wr_bank] = 1'b0;
      if (cmd == C_PRE) begin
        if (addr[AP_BIT]) nxt = '0;
        else nxt[ba] = 1'b0;
      end
      if (cmd == C_ACT) nxt[ba] = 1'b1;
      bank_open <= nxt;
    end
  end
endmodule

// File: rtl/sdram_wr_capture_chk.sv
module sdram_wr_capture_chk
  import sdram_wc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input cmd_e       cmd,
  input logic       burst_on,
  input logic       wr_fire,
  input logic       dqm,
  input logic [2:0] blen_sel,
  input logic       pre_err,
  input logic       trunc_pre
);
  // R8
  mask_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> !wr_fire);
  // R7
  bst_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BST) |-> !wr_fire);
  // R6
  read_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && burst_on) |=> !burst_on);
  // R5
  write_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR && blen_sel != 3'd0) |=> burst_on);
  // R11
  err_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_err |-> $past(trunc_pre));
  // R2
  store_needs_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (cmd == C_WR || burst_on));
endmodule

bind sdram_wr_capture sdram_wr_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .burst_on(burst_on),
  .wr_fire(wr_fire), .dqm(dqm), .blen_sel(blen_sel),
  .pre_err(pre_err), .trunc_pre(trunc_pre)
);

// File: tb/sdram_wr_capture_test.sv
`timescale 1ns/1ps
module sdram_wr_capture_test;
  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_BST = 4'b0110, K_PRE = 4'b0010;

  logic       clk = 0, rst_n = 0;
  logic       cs_n = 0, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [10:0] addr = 0;
  logic [7:0] din = 0;
  logic       dqm = 1;
  logic [2:0] blen_sel = 0;
  logic [1:0] peek_bank = 0;
  logic [7:0] peek_col = 0;
  logic [7:0] peek_data;
  logic       burst_on, pre_err;
  logic [3:0] bank_open;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mem_m [4][256];
  bit act_m = 0, full_m = 0, ap_m = 0, perr_m = 0, dprev_m = 1;
  int cb_m = 0, cc_m = 0, left_m = 0, bl_m = 1, lastb = 0, lastc = 0;
  logic [3:0] open_m = 0;

  sdram_wr_capture uut (.*);

  always #10 clk = ~clk;

  function automatic int nxt(int c, int bl, bit full);
    int base;
    if (full) return (c + 1) % 256;
    base = c - (c % bl);
    return base + ((c % bl) + 1) % bl;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [3:0] k;
    int bl;
    bit full, stop;
    k = {cs_n, ras_n, cas_n, we_n};
    perr_m = 0;
    if (k == K_WR) begin
      bl = 1 << blen_sel;
      full = blen_sel > 3;
      lastb = ba; lastc = addr[7:0];
      if (!dqm) mem_m[ba][addr[7:0]] = din;
      if (!full && bl == 1) begin
        act_m = 0;
        if (addr[10]) open_m[ba] = 0;
      end else begin
        act_m = 1; cb_m = ba; bl_m = bl; full_m = full; ap_m = addr[10];
        cc_m = nxt(addr[7:0], bl, full); left_m = bl - 1;
      end
    end else if (act_m) begin
      stop = (k == K_RD) || (k == K_BST) ||
             (k == K_PRE && (addr[10] || ba == cb_m));
      if (stop) begin
        act_m = 0;
        if (k == K_PRE && (!dqm || !dprev_m)) perr_m = 1;
      end else begin
        lastb = cb_m; lastc = cc_m;
        if (!dqm) mem_m[cb_m][cc_m] = din;
        if (!full_m && left_m == 1) begin
          act_m = 0;
          if (ap_m) open_m[cb_m] = 0;
        end else begin
          cc_m = nxt(cc_m, bl_m, full_m);
          left_m--;
        end
      end
    end
    if (k == K_PRE) begin
      if (addr[10]) open_m = 0; else open_m[ba] = 0;
    end
    if (k == K_ACT) open_m[ba] = 1;
    dprev_m = dqm;
  endtask

  task automatic cyc(input logic [3:0] k, input logic [1:0] b,
                     input logic [10:0] a, input logic [7:0] d, input logic m,
                     input string req);
    {cs_n, ras_n, cas_n, we_n} = k;
    ba = b; addr = a; din = d; dqm = m;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({req, " burst_on"}, burst_on, act_m);
    check({req, " bank_open"}, bank_open, open_m);
    check({req, " pre_err"}, pre_err, perr_m);
    peek_bank = lastb[1:0]; peek_col = lastc[7:0];
    #1;
    check({req, " data"}, peek_data, mem_m[lastb][lastc]);
  endtask

  task automatic idle(int n, logic [7:0] d, string req);
    for (int i = 0; i < n; i++) cyc(K_NOP, 0, 0, d + 8'(i), 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 256; c++) mem_m[b][c] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 burst_on", burst_on, 0);
    check("R12 bank_open", bank_open, 0);
    check("R12 pre_err", pre_err, 0);
    peek_bank = 2; peek_col = 8'h33; #1;
    check("R12 data", peek_data, 0);

    // R9 open all banks; R1 deselected command does nothing
    for (int b = 0; b < 4; b++) cyc(K_ACT, 2'(b), 0, 0, 1, "R9 act");
    cyc(4'b1100, 1, 11'h010, 8'h77, 0, "R1 deselect");

    // R1 R2 R3: length 4 from column 5 wraps in block, then data ignored
    blen_sel = 2;
    cyc(K_WR, 0, 11'h005, 8'hA0, 0, "R1 first");
    for (int i = 1; i < 4; i++) cyc(K_NOP, 0, 0, 8'hA0 + 8'(i), 0, "R2 next");
    idle(2, 8'hEE, "R3 ignored");

    // R8 length 8 with a masked slot
    blen_sel = 3;
    cyc(K_WR, 1, 11'h013, 8'hB0, 0, "R8 start");
    cyc(K_NOP, 1, 0, 8'hB1, 0, "R8 s1");
    cyc(K_NOP, 1, 0, 8'hB2, 1, "R8 masked");
    for (int i = 3; i < 8; i++) cyc(K_NOP, 1, 0, 8'hB0 + 8'(i), 0, "R8 rest");
    idle(1, 8'hEF, "R3 after 8");

    // R9 auto precharge: length 1 and length 2 wrapping at 0xFF
    blen_sel = 0;
    cyc(K_WR, 1, 11'h400 | 11'h0AA, 8'hC1, 0, "R9 bl1 ap");
    blen_sel = 1;
    cyc(K_WR, 2, 11'h400 | 11'h0FF, 8'hC2, 0, "R9 bl2 ap");
    cyc(K_NOP, 2, 0, 8'hC3, 0, "R9 bl2 close");
    idle(1, 8'hC4, "R3 after 2");
    cyc(K_ACT, 1, 0, 0, 1, "R9 reopen1");
    cyc(K_ACT, 2, 0, 0, 1, "R9 reopen2");

    // R4 full page wraps, R7 terminate drops its data
    blen_sel = 7;
    cyc(K_WR, 3, 11'h0FC, 8'hD0, 0, "R4 start");
    for (int i = 1; i < 7; i++) cyc(K_NOP, 3, 0, 8'hD0 + 8'(i), 0, "R4 wrap");
    cyc(K_BST, 3, 0, 8'hDF, 0, "R7 bst");
    idle(2, 8'hDE, "R7 after");

    // R5 new write truncates, R6 read ends burst
    blen_sel = 3;
    cyc(K_WR, 0, 11'h040, 8'h50, 0, "R5 first");
    cyc(K_NOP, 0, 0, 8'h51, 0, "R5 s1");
    cyc(K_WR, 1, 11'h080, 8'h60, 0, "R5 new");
    cyc(K_NOP, 1, 0, 8'h61, 0, "R5 s1 new");
    cyc(K_RD, 1, 0, 8'h6F, 0, "R6 read");
    idle(2, 8'h6E, "R6 after");

    // R10 precharge elsewhere continues; own bank ends with R11 error
    cyc(K_WR, 2, 11'h020, 8'h70, 0, "R10 start");
    cyc(K_PRE, 1, 0, 8'h71, 0, "R10 other bank");
    cyc(K_NOP, 2, 0, 8'h72, 0, "R10 s2");
    cyc(K_PRE, 2, 0, 8'h7F, 0, "R11 err pre");
    idle(1, 8'h7E, "R11 after");
    cyc(K_ACT, 2, 0, 0, 1, "R10 reopen");
    // R11 masked properly: no error; precharge all (addr[10])
    cyc(K_WR, 0, 11'h030, 8'h90, 0, "R11 start");
    cyc(K_NOP, 0, 0, 8'h91, 1, "R11 masked before");
    cyc(K_PRE, 3, 11'h400, 8'h9F, 1, "R10 pre all");
    idle(1, 8'h9E, "R11 no err");

    // R2 natural completion with auto precharge off keeps bank open
    cyc(K_ACT, 3, 0, 0, 1, "R9 reopen3");
    cyc(K_WR, 3, 11'h0F6, 8'hE0, 0, "R2 bl8 start");
    for (int i = 1; i < 8; i++) cyc(K_NOP, 3, 0, 8'hE0 + 8'(i), 0, "R2 bl8");
    idle(2, 8'hEA, "R3 final");

    // full array sweep
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 256; c++) begin
        peek_bank = 2'(b); peek_col = 8'(c); #1;
        check("R1 sweep", peek_data, mem_m[b][c]);
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule